// File: doc/BRIEF.md
# Serial Converter Readout Controller

This block is the host-side master for a 12-bit sampling converter that speaks a three-wire serial protocol: an active-low select, a serial clock supplied by the host, and one data line from the converter. The controller runs from a fast system clock and derives the serial clock by dividing it. It frames each conversion with the select line and takes one bit from the data line at each rising serial clock. It drops the four leading zero bits, flags them if any of them is not zero, and hands each 12-bit two's-complement result to the fabric sign-extended to 16 bits.

A pulse on `start` begins a frame. Three modes exist. A single frame reads one full sample. A streaming frame keeps select low for a programmed number of back-to-back samples. A clipped frame ends after a programmed number of result bits and returns the result left-aligned and marked partial. Between frames, select is high and the serial clock is parked low.

Results leave on a valid/ready port. The converter cannot be stalled, so back-pressure never slows the serial side. A result is held stable until it is accepted. If a newer result completes while the old one is still waiting, the newer one replaces it.

Top module: `adcrd_ctrl`

## Requirements
- R1: After reset: `spi_cs_n`=1, `spi_sclk`=0, `busy`=0, `done`=0, `res_valid`=0 and `lead_err`=0.
- R2: While a frame runs, `spi_sclk` is low for HALF_DIV system cycles and then high for HALF_DIV system cycles. The first low phase starts on the edge where `spi_cs_n` falls, so the clock never rises with select. `spi_sclk` is low whenever `spi_cs_n` is high.
- R3: `spi_miso` is sampled on the system edge at which `spi_sclk` goes high. Within each sample, bits 0 to 3 are leading bits and bits 4 to 15 are the result, most significant bit first, in two's complement.
- R4: `res_data` is the 12-bit result sign-extended to 16 bits. `res_valid` rises on the same system edge that samples the last result bit.
- R5: When `mode`=0 (single) or `mode`=3 (treated as single), a frame has 16 serial clocks. `spi_cs_n` stays low for exactly 32*HALF_DIV system cycles.
- R6: When `mode`=1 (stream), the frame carries `sample_count` samples back to back (0 counts as 1), 16 clocks each, with `spi_cs_n` held low throughout. One result is produced per sample.
- R7: When `mode`=2 (clip) and `short_bits`=K with 1<=K<=11, the frame ends after 4+K serial clocks. The K received bits occupy the top of the 12-bit field, the bits below them are zero, and `res_partial`=1. A K of 0 or 12 and above gives a full frame with `res_partial`=0.
- R8: `lead_err` is set when any leading bit is sampled as 1, and it stays set until reset.
- R9: A `start` pulse while `busy`=1 has no effect.
- R10: `done` is a one-cycle pulse in the cycle in which `spi_cs_n` returns high. `busy` falls in that same cycle.
- R11: While `res_valid`=1 and `res_ready`=0, `res_data` and `res_partial` hold unless a newer result completes, and the newer result replaces the old one. `res_valid` clears after an edge with `res_ready`=1.
- R12: `mode`, `sample_count` and `short_bits` are sampled only on the edge that accepts `start`. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame when idle |
| mode | input | 2 | 0 single, 1 stream, 2 clip, 3 single |
| sample_count | input | CNT_W | Samples per stream frame (0 means 1) |
| short_bits | input | 4 | Result bits kept in clip mode |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse as select rises |
| lead_err | output | 1 | Sticky: a leading bit read as 1 |
| spi_cs_n | output | 1 | Converter select, active low |
| spi_sclk | output | 1 | Serial clock to the converter |
| spi_miso | input | 1 | Serial data from the converter |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_data | output | 16 | Sign-extended result |
| res_partial | output | 1 | Result came from a clipped frame |

## Verification
A wrong phase or bit counter shows up on `spi_sclk` or `spi_cs_n` in the same cycle it diverges, and the bench compares both against its model on every clock. A bit index that is off by one moves the capture point. A wrong result word therefore appears on `res_data` at the very next `res_valid`, at most 32*HALF_DIV cycles later. A sample counter that is off shows up as a frame length that differs by 32*HALF_DIV cycles, and as a `done` that comes early or late.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
  localparam int RD_LEAD_BITS  = 4;
  localparam int RD_DATA_BITS  = 12;
  localparam int RD_FRAME_CLKS = RD_LEAD_BITS + RD_DATA_BITS;
  localparam int RD_OUT_W      = 16;
  localparam int RD_BIT_W      = $clog2(RD_FRAME_CLKS);

  typedef enum logic [1:0] {
    RD_SINGLE = 2'd0,
    RD_STREAM = 2'd1,
    RD_CLIP   = 2'd2,
    RD_RSVD   = 2'd3
  } rd_mode_e;
endpackage

// File: rtl/adcrd_phase_timer.sv
module adcrd_phase_timer #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run)          cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/adcrd_frame_ctl.sv
module adcrd_frame_ctl
  import adcrd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [1:0]          mode,
  input  logic [CNT_W-1:0]    sample_count,
  input  logic [RD_BIT_W-1:0] short_bits,
  input  logic                tick,
  output logic                active,
  output logic                cs_n,
  output logic                sclk,
  output logic                done,
  output logic                cap,
  output logic                cap_last,
  output logic [RD_BIT_W-1:0] cap_bit,
  output logic [RD_BIT_W-1:0] keep_bits,
  output logic                partial
);
  localparam logic [RD_BIT_W-1:0] FULL_K   = RD_BIT_W'(RD_DATA_BITS);
  localparam logic [RD_BIT_W-1:0] LEAD_OFS = RD_BIT_W'(RD_LEAD_BITS - 1);
  localparam logic [RD_BIT_W-1:0] TOP_BIT  = RD_BIT_W'(RD_FRAME_CLKS - 1);

  rd_mode_e            mode_e;
  logic                clip_d;
  logic [RD_BIT_W-1:0] keep_d;
  logic [CNT_W-1:0]    left_d;

  logic                sclk_q, done_q, part_q;
  logic [RD_BIT_W-1:0] bit_q, last_q, keep_q;
  logic [CNT_W-1:0]    left_q;

  assign mode_e = rd_mode_e'(mode);

  always_comb begin
    clip_d = (mode_e == RD_CLIP) && (short_bits != '0) && (short_bits < FULL_K);
    keep_d = clip_d ? short_bits : FULL_K;
    if (mode_e == RD_STREAM && sample_count != '0) left_d = sample_count - 1'b1;
    else                                           left_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      part_q <= 1'b0;
      bit_q  <= '0;
      last_q <= '0;
      keep_q <= FULL_K;
      left_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          sclk_q <= 1'b0;
          bit_q  <= '0;
          keep_q <= keep_d;
          last_q <= keep_d + LEAD_OFS;
          part_q <= clip_d;
          left_q <= left_d;
        end
      end else if (tick) begin
        if (!sclk_q) begin
          sclk_q <= 1'b1;
        end else if (bit_q == last_q && left_q == '0) begin
          sclk_q <= 1'b0;
          active <= 1'b0;
          done_q <= 1'b1;
        end else begin
          sclk_q <= 1'b0;
          if (bit_q == TOP_BIT) begin
            bit_q  <= '0;
            left_q <= left_q - 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
      end
    end
  end

  assign cs_n      = ~active;
  assign sclk      = sclk_q;
  assign done      = done_q;
  assign cap       = tick && !sclk_q;
  assign cap_last  = cap && (bit_q == last_q);
  assign cap_bit   = bit_q;
  assign keep_bits = keep_q;
  assign partial   = part_q;

  assert_sclk_only_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);
  assert_no_rise_after_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |=> !sclk);
  assert_done_with_select_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> done);
  assert_done_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_start_ignored_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && start) |=> ($stable(last_q) && $stable(part_q)));
endmodule

// File: rtl/adcrd_result_asm.sv
module adcrd_result_asm
  import adcrd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                miso,
  input  logic                cap,
  input  logic                cap_last,
  input  logic [RD_BIT_W-1:0] cap_bit,
  input  logic [RD_BIT_W-1:0] keep_bits,
  input  logic                partial,
  input  logic                res_ready,
  output logic                res_valid,
  output logic [RD_OUT_W-1:0] res_data,
  output logic                res_partial,
  output logic                lead_err
);
  localparam logic [RD_BIT_W-1:0] LEAD_L = RD_BIT_W'(RD_LEAD_BITS);
  localparam logic [RD_BIT_W-1:0] DATA_L = RD_BIT_W'(RD_DATA_BITS);
  localparam int EXT_W = RD_OUT_W - RD_DATA_BITS;

  logic [RD_DATA_BITS-1:0] shreg_q, word_d, aligned_d;
  logic [RD_BIT_W-1:0]     shamt_d;
  logic                    in_lead;

  assign in_lead   = cap_bit < LEAD_L;
  assign word_d    = {shreg_q[RD_DATA_BITS-2:0], miso};
  assign shamt_d   = DATA_L - keep_bits;
  assign aligned_d = word_d << shamt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q     <= '0;
      lead_err    <= 1'b0;
      res_valid   <= 1'b0;
      res_data    <= '0;
      res_partial <= 1'b0;
    end else begin
      if (cap) begin
        if (in_lead) begin
          shreg_q <= '0;
          if (miso) lead_err <= 1'b1;
        end else begin
          shreg_q <= word_d;
        end
      end
      if (cap_last) begin
        res_valid   <= 1'b1;
        res_data    <= {{EXT_W{aligned_d[RD_DATA_BITS-1]}}, aligned_d};
        res_partial <= partial;
      end else if (res_valid && res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end

  assert_hold_under_backpressure_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready && !cap_last) |=>
      (res_valid && $stable(res_data) && $stable(res_partial)));
  assert_lead_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lead_err |=> lead_err);
  assert_result_sign_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_data[RD_OUT_W-1:RD_DATA_BITS] == {EXT_W{res_data[RD_DATA_BITS-1]}}));
endmodule

// File: rtl/adcrd_ctrl.sv
module adcrd_ctrl
  import adcrd_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [1:0]          mode,
  input  logic [CNT_W-1:0]    sample_count,
  input  logic [3:0]          short_bits,
  output logic                busy,
  output logic                done,
  output logic                lead_err,
  output logic                spi_cs_n,
  output logic                spi_sclk,
  input  logic                spi_miso,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [15:0]         res_data,
  output logic                res_partial
);
  logic                tick, active, cap, cap_last, partial;
  logic [RD_BIT_W-1:0] cap_bit, keep_bits;

  adcrd_phase_timer #(.HALF_DIV(HALF_DIV)) timer_i (
    .clk(clk), .rst_n(rst_n), .run(active), .tick(tick)
  );

  adcrd_frame_ctl #(.CNT_W(CNT_W)) frame_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .sample_count(sample_count), .short_bits(short_bits), .tick(tick),
    .active(active), .cs_n(spi_cs_n), .sclk(spi_sclk), .done(done),
    .cap(cap), .cap_last(cap_last), .cap_bit(cap_bit),
    .keep_bits(keep_bits), .partial(partial)
  );

  adcrd_result_asm asm_i (
    .clk(clk), .rst_n(rst_n), .miso(spi_miso), .cap(cap),
    .cap_last(cap_last), .cap_bit(cap_bit), .keep_bits(keep_bits),
    .partial(partial), .res_ready(res_ready), .res_valid(res_valid),
    .res_data(res_data), .res_partial(res_partial), .lead_err(lead_err)
  );

  assign busy = active;
endmodule

// File: tb/adcrd_ctrl_tb.sv
module adcrd_ctrl_tb_top;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] sample_count = 8'd0;
  logic [3:0] short_bits = 4'd0;
  logic res_ready = 1'b1;
  logic busy, done, lead_err, spi_cs_n, spi_sclk, res_valid, res_partial;
  logic [15:0] res_data;
  logic miso_r = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  adcrd_ctrl #(.HALF_DIV(HALF), .CNT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .sample_count(sample_count), .short_bits(short_bits),
    .busy(busy), .done(done), .lead_err(lead_err),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_miso(miso_r),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_partial(res_partial)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // converter model: data line changes after falling serial clock
  logic [15:0] adc_q[$];
  logic [15:0] pend_q[$];
  logic [15:0] adc_w = 16'h0;
  int adc_p = 0;
  always @(negedge spi_cs_n) begin
    adc_w = (adc_q.size() != 0) ? adc_q.pop_front() : 16'h0;
    adc_p = 0;
    miso_r = adc_w[15];
  end
  always @(negedge spi_sclk) begin
    if (!spi_cs_n) begin
      adc_p++;
      if (adc_p == 16) begin
        adc_p = 0;
        adc_w = (adc_q.size() != 0) ? adc_q.pop_front() : 16'h0;
      end
      miso_r = adc_w[15 - adc_p];
    end
  end

  function automatic logic [15:0] exp_res(input logic [15:0] w, input int k);
    logic [11:0] d;
    d = w[11:0];
    if (k < 12) d = (d >> (12 - k)) << (12 - k);
    return {{4{d[11]}}, d};
  endfunction

  // cycle-by-cycle reference model
  logic [15:0] m_words[$];
  bit m_act = 0, m_valid = 0, m_err = 0, m_done = 0, m_part = 0, m_clip = 0;
  logic [15:0] m_data = 16'h0;
  int m_n = 0, m_T = 16, m_k = 12;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_valid = 0; m_err = 0; m_done = 0; m_part = 0; m_data = 16'h0;
    end else begin
      m_done = 0;
      if (m_valid && res_ready) m_valid = 0;
      if (m_act) begin
        m_n++;
        if (m_n % (2 * HALF) == HALF) begin
          int j, jb;
          logic [15:0] w;
          j  = (m_n - HALF) / (2 * HALF);
          jb = j % 16;
          w  = m_words[j / 16];
          if (jb < 4 && w[15 - jb]) m_err = 1;
          if (jb == 3 + m_k) begin
            m_valid = 1; m_data = exp_res(w, m_k); m_part = m_clip;
          end
        end
        if (m_n == 2 * m_T * HALF) begin m_act = 0; m_done = 1; end
      end else if (start) begin
        m_act = 1; m_n = 0;
        m_words = pend_q; pend_q.delete();
        m_clip = (mode == 2'd2) && (short_bits >= 1) && (short_bits <= 11);
        m_k = m_clip ? int'(short_bits) : 12;
        if (m_clip) m_T = 4 + m_k;
        else if (mode == 2'd1) m_T = 16 * ((sample_count == 0) ? 1 : int'(sample_count));
        else m_T = 16;
      end
    end
  end

  // per-cycle comparison and port monitors
  int low_cnt = 0, last_len = 0, done_cnt = 0, res_cnt = 0;
  bit prev_valid = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(spi_cs_n == !m_act, "R2 cs_n", spi_cs_n, !m_act);
      chk(spi_sclk == (m_act && ((m_n / HALF) % 2 == 1)), "R2 R3 sclk", spi_sclk,
          m_act && ((m_n / HALF) % 2 == 1));
      chk(busy == m_act, "R10 busy", busy, m_act);
      chk(done == m_done, "R10 done", done, m_done);
      chk(res_valid == m_valid, "R11 res_valid", res_valid, m_valid);
      chk(lead_err == m_err, "R8 lead_err", lead_err, m_err);
      if (m_valid) begin
        chk(res_data == m_data, "R3 R4 res_data", res_data, m_data);
        chk(res_partial == m_part, "R7 res_partial", res_partial, m_part);
      end
      if (!spi_cs_n) low_cnt++;
      if (done) begin last_len = low_cnt; low_cnt = 0; done_cnt++; end
      if (res_valid && !prev_valid) res_cnt++;
      prev_valid = res_valid;
    end
  end

  task automatic frame(input logic [1:0] md, input logic [7:0] cnt, input logic [3:0] kb,
                       input int nw, input logic [15:0] w0, input logic [15:0] w1,
                       input logic [15:0] w2);
    logic [15:0] ws[3];
    ws[0] = w0; ws[1] = w1; ws[2] = w2;
    for (int i = 0; i < nw; i++) begin adc_q.push_back(ws[i]); pend_q.push_back(ws[i]); end
    done_cnt = 0; res_cnt = 0;
    @(negedge clk);
    mode = md; sample_count = cnt; short_bits = kb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks + 0);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(spi_cs_n == 1 && spi_sclk == 0 && busy == 0 && done == 0 && res_valid == 0
        && lead_err == 0, "R1 reset state", {spi_cs_n, spi_sclk, busy, done, res_valid, lead_err},
        6'b100000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5 single frames, positive and negative full scale
    frame(2'd0, 8'd0, 4'd0, 1, 16'h07FF, 0, 0);
    chk(last_len == 32 * HALF, "R5 single frame length", last_len, 32 * HALF);
    frame(2'd3, 8'd9, 4'd0, 1, 16'h0800, 0, 0);
    chk(last_len == 32 * HALF, "R5 mode 3 frame length", last_len, 32 * HALF);
    chk(res_cnt == 1, "R5 one result", res_cnt, 1);

    // R6 stream of three samples
    frame(2'd1, 8'd3, 4'd0, 3, 16'h0123, 16'h0FFF, 16'h0555);
    chk(last_len == 3 * 32 * HALF, "R6 stream length", last_len, 3 * 32 * HALF);
    chk(res_cnt == 3, "R6 results per stream", res_cnt, 3);
    frame(2'd1, 8'd0, 4'd0, 1, 16'h0ABC, 0, 0);
    chk(last_len == 32 * HALF, "R6 count zero acts as one", last_len, 32 * HALF);

    // R7 clipped frames
    frame(2'd2, 8'd0, 4'd1, 1, 16'h0A55, 0, 0);
    chk(last_len == 2 * 5 * HALF, "R7 clip K=1 length", last_len, 2 * 5 * HALF);
    frame(2'd2, 8'd0, 4'd5, 1, 16'h0A55, 0, 0);
    chk(last_len == 2 * 9 * HALF, "R7 clip K=5 length", last_len, 2 * 9 * HALF);
    frame(2'd2, 8'd0, 4'd12, 1, 16'h0A55, 0, 0);
    chk(last_len == 32 * HALF, "R7 clip K=12 full", last_len, 32 * HALF);
    frame(2'd2, 8'd0, 4'd0, 1, 16'h0321, 0, 0);
    chk(last_len == 32 * HALF, "R7 clip K=0 full", last_len, 32 * HALF);

    // R9 start while busy, R12 config changes mid-frame
    adc_q.push_back(16'h0F0F); pend_q.push_back(16'h0F0F);
    done_cnt = 0;
    @(negedge clk);
    mode = 2'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    mode = 2'd2; short_bits = 4'd2; sample_count = 8'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(last_len == 32 * HALF, "R12 config latched at start", last_len, 32 * HALF);
    repeat (4) @(negedge clk);
    chk(done_cnt == 1 && !busy, "R9 busy start ignored", done_cnt, 1);

    // R11 back-pressure: latest result wins
    res_ready = 1'b0;
    frame(2'd1, 8'd3, 4'd0, 3, 16'h0111, 16'h0222, 16'h0F33);
    chk(res_valid && res_data == 16'hFF33, "R11 latest result held", res_data, 16'hFF33);
    res_ready = 1'b1;
    @(negedge clk);
    chk(!res_valid, "R11 valid clears after accept", res_valid, 0);

    // R8 leading bit error, sticky
    chk(!lead_err, "R8 clear before", lead_err, 0);
    frame(2'd0, 8'd0, 4'd0, 1, 16'h4123, 0, 0);
    chk(lead_err, "R8 set by leading one", lead_err, 1);
    frame(2'd0, 8'd0, 4'd0, 1, 16'h0123, 0, 0);
    chk(lead_err, "R8 sticky", lead_err, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule